// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block collects completion events from sixteen DMA channels and merges them into a single interrupt request for the processor. Each channel raises two kinds of single-cycle pulse. One marks the point where half of its transfer is done. The other marks the end of the transfer. Each pulse lands in its own bit of a pending register, but only if the matching bit of an enable register is set. The interrupt line stays high for as long as some enabled event is still pending.

Software reaches both registers through a simple register port with a write strobe, an address, write data and a combinational read-back. The enable register is written directly. The pending register is cleared bit by bit by writing ones. A handler can therefore clear exactly the events it has serviced, or clear everything with one all-ones write. The channels fall into two groups of eight, 0 to 7 and 8 to 15. Both groups share the one register pair and the one interrupt line.

Top module: `dma_evt_irq`

## Requirements
- R1: While reset is asserted and immediately after it, the enable and pending registers read 0 and `irq` is low.
- R2: A write at offset 0x0 loads all 32 bits of the enable register; reading offset 0x0 returns it.
- R3: Channel n maps to two register bits: its half-transfer pulse goes to bit 2n and its end-of-transfer pulse goes to bit 2n+1. When the enable bit is 1, the pulse sets the pending bit, and the bit reads as 1 at offset 0x4 from the next cycle on.
- R4: A pulse whose enable bit is 0 is ignored: the pending bit stays 0.
- R5: A write at offset 0x4 clears each pending bit written with 1 and leaves each bit written with 0 unchanged.
- R6: Writing 0xFFFFFFFF at offset 0x4 clears all pending bits in one cycle.
- R7: If an enabled pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some bit is set in both the pending and the enable register. Clearing an enable bit lowers `irq` but leaves the pending bit in place.
- R9: A write at offset 0x4 does not change the enable register. A write to any other offset that is not 0x0 changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_evt | input | NUM_CH | Half-transfer pulse, one bit per channel |
| end_evt | input | NUM_CH | End-of-transfer pulse, one bit per channel |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 2*NUM_CH | Register write data |
| reg_rdata | output | 2*NUM_CH | Read data for the register at `reg_addr` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bound assertions check on every cycle that:
- every enabled pulse sets its pending bit, even when a clearing write hits the same bit;
- no pending bit rises without an enabled pulse behind it;
- bits written with one drop and all other bits hold;
- the enable register follows only writes to its own offset;
- `irq` is never high while nothing is pending and enabled.

Some behaviours only the bench scenarios can show, because they need values read through the register port:
- that each channel's two pulses land at the right bit positions;
- that an all-ones write empties the register;
- that reset returns everything to zero in the middle of a run.

// File: rtl/dma_evt_irq.sv
module dma_evt_irq #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     half_evt,
  input  logic [NUM_CH-1:0]     end_evt,
  input  logic                  reg_wen,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [2*NUM_CH-1:0]   reg_wdata,
  output logic [2*NUM_CH-1:0]   reg_rdata,
  output logic                  irq
);
  localparam int DW = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] EN_OFS   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PEND_OFS = ADDR_W'(4);

  logic [DW-1:0] en_r, pend_r, evt_vec, clr_mask, set_mask;
  logic          wr_en, wr_pend;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_pair
    assign evt_vec[2*n]   = half_evt[n];
    assign evt_vec[2*n+1] = end_evt[n];
  end

  assign wr_en    = reg_wen && (reg_addr == EN_OFS);
  assign wr_pend  = reg_wen && (reg_addr == PEND_OFS);
  assign clr_mask = wr_pend ? reg_wdata : '0;
  assign set_mask = evt_vec & en_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= '0;
      pend_r <= '0;
    end else begin
      if (wr_en) en_r <= reg_wdata;
      pend_r <= (pend_r & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    case (reg_addr)
      EN_OFS:   reg_rdata = en_r;
      PEND_OFS: reg_rdata = pend_r;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |(pend_r & en_r);
endmodule

module dma_evt_irq_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     evt_vec,
  input logic [DW-1:0]     en_r,
  input logic [DW-1:0]     pend_r,
  input logic              irq
);
  logic [DW-1:0] ones_wr, armed;
  logic          en_write, other_write;
  assign ones_wr     = (reg_wen && reg_addr == ADDR_W'(4)) ? reg_wdata : '0;
  assign armed       = evt_vec & en_r;
  assign en_write    = reg_wen && reg_addr == ADDR_W'(0);
  assign other_write = reg_wen && reg_addr != ADDR_W'(0);

  AST_EVT_SETS:   assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pend_r & $past(armed)) == $past(armed)));  // R3 R7
  AST_NO_SPUR:    assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pend_r & ~$past(pend_r) & ~$past(armed)) == '0)); // R4
  AST_W1C:        assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pend_r & $past(ones_wr) & ~$past(armed)) == '0)); // R5
  AST_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (($past(pend_r) & ~$past(ones_wr) & ~pend_r) == '0)); // R5
  AST_EN_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) en_write |=> (en_r == $past(reg_wdata)));  // R2
  AST_EN_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) (!en_write || other_write) |=> $stable(en_r)); // R9
  AST_IRQ_SRC:    assert property (@(posedge clk) disable iff (!rst_n) irq |-> (pend_r != '0 && en_r != '0));  // R8
endmodule

bind dma_evt_irq dma_evt_irq_chk #(.DW(2*NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_vec(evt_vec), .en_r(en_r), .pend_r(pend_r), .irq(irq)
);

// File: tb/dma_evt_irq_tb.sv
`timescale 1ns/100ps
module dma_evt_irq_tb_top;
  localparam int NCH = 16;
  localparam int VW  = 133;
  localparam int NV  = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  half_evt = '0, end_evt = '0;
  logic            reg_wen = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq;
  int              n_chk = 0, n_bad = 0;
  bit              done = 1'b0;

  always #2 clk = ~clk;

  dma_evt_irq #(.NUM_CH(NCH), .ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_evt(half_evt), .end_evt(end_evt),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // {half, end, wen, addr, wdata, exp_en, exp_pend, exp_irq}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b1, 3'd0, 32'h0000000F, 32'h0000000F, 32'h00000000, 1'b0}, // R2
    {16'h0001, 16'h0002, 1'b0, 3'd0, 32'h00000000, 32'h0000000F, 32'h00000009, 1'b1}, // R3 pair mapping
    {16'h0010, 16'h0000, 1'b0, 3'd0, 32'h00000000, 32'h0000000F, 32'h00000009, 1'b1}, // R4 disabled bit 8
    {16'h0000, 16'h0000, 1'b1, 3'd4, 32'h00000001, 32'h0000000F, 32'h00000008, 1'b1}, // R5 R9
    {16'h0000, 16'h0002, 1'b1, 3'd4, 32'h00000008, 32'h0000000F, 32'h00000008, 1'b1}, // R7 set wins
    {16'h0000, 16'h0000, 1'b1, 3'd0, 32'h00000000, 32'h00000000, 32'h00000008, 1'b0}, // R8 masked
    {16'h0000, 16'h0000, 1'b1, 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000008, 1'b1}, // R8 unmasked
    {16'hFFFF, 16'hFFFF, 1'b0, 3'd0, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1}, // R3 all
    {16'h0000, 16'h0000, 1'b1, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R6
    {16'h0000, 16'h0000, 1'b1, 3'd2, 32'h12345678, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R9 other offset
    {16'h0000, 16'h8000, 1'b0, 3'd0, 32'h00000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}  // R3 top channel
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic readall(input int rq, input logic [31:0] e_en, input logic [31:0] e_pd, input logic e_irq);
    reg_addr = 3'd0; #0.5;
    chk(rq, reg_rdata, e_en, "enable");
    reg_addr = 3'd4; #0.5;
    chk(rq, reg_rdata, e_pd, "pending");
    chk(rq, {31'd0, irq}, {31'd0, e_irq}, "irq");
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    readall(1, 32'h0, 32'h0, 1'b0); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    readall(1, 32'h0, 32'h0, 1'b0); // R1 after release
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      half_evt  = v[132:117];
      end_evt   = v[116:101];
      reg_wen   = v[100];
      reg_addr  = v[99:97];
      reg_wdata = v[96:65];
      @(negedge clk);
      half_evt = '0; end_evt = '0; reg_wen = 1'b0; reg_wdata = '0;
      readall(i + 1 > 9 ? 3 : (i == 0 ? 2 : 5), v[64:33], v[32:1], v[0]);
    end
    // R1: reset in mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    readall(1, 32'h0, 32'h0, 1'b0);
    rst_n = 1'b1;
    // R4: pulse right after reset with all enables zero
    @(negedge clk);
    half_evt = '1; end_evt = '1;
    @(negedge clk);
    half_evt = '0; end_evt = '0;
    readall(4, 32'h0, 32'h0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule